// File: doc/BRIEF.md
# Double-Buffered PWM Generator with Sub-Count Resolution

This block makes a pulse-width modulated waveform whose duty cycle has two more bits of resolution than its period timer. A coarse timer counts whole period steps and a small sub-counter below it counts enable ticks inside each step. Together they form an extended time base, and the duty value is compared against that time base. The period is set by a coarse period register. A period ends when the coarse timer equals the period register and the sub-counter has reached its top value.

Software writes a period value, the upper duty bits, and a control byte. The control byte carries the low duty bits and a run bit. The duty value written is only a master copy. At each period boundary it is copied into a slave copy, and only the slave copy drives the compare. A duty change therefore never alters a period already under way. Clearing the run bit stops the time base and forces the output low.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: While running, the sub-counter advances by one on every cycle with `tick_en` high, and the coarse timer advances by one when the sub-counter wraps from 3 to 0. On cycles with `tick_en` low the time base holds.
- R2: On a tick where the coarse timer equals the period register and the sub-counter is 3, both counters return to zero. With a tick every cycle, a period therefore lasts (P+1)*4 cycles.
- R3: At a period boundary the output goes high in the cycle after the tick, provided the newly latched duty is nonzero. It goes low on the tick that brings the extended time base {timer, sub} equal to the latched duty, so it stays high for D ticks.
- R4: The duty value is {duty-high byte written at `wr_sel`=1, control bits [1:0] written at `wr_sel`=2}. The period is written at `wr_sel`=0. Control bit 2 is the run bit.
- R5: A write to either duty field changes the waveform only from the next period boundary on.
- R6: A latched duty of zero keeps the output low for the whole period. A latched duty of at least (P+1)*4 keeps it high for the whole period.
- R7: While the run bit is clear, the counters are held at zero and the output is low from the next cycle on. After reset everything is zero and the output is low.
- R8: After the run bit is set, the first period starts at time base zero with the output low until the first period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time-base advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 period, 1 duty high, 2 control |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
Every cycle, the assertions check the following:
- the time base holds without a tick and clears at a boundary or while stopped;
- the slave duty changes only at a boundary;
- the output rises only just after a boundary;
- a zero duty or a cleared run bit leaves the output low;
- a duty-high write lands in the master copy.

The exact high time in ticks needs the bench's reference model, which is compared against the output on every clock. The same applies to the period length under sparse ticks, the deferral of mid-period duty writes, the always-high case for oversized duty, and the low first period after enabling.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
   typedef enum logic [1:0] {
      SEL_PERIOD = 2'd0,
      SEL_DUTY_HI = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_t;
endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
   import pwm_dbuf_pkg::*;
#(
   parameter int TMR_W = 8,
   parameter int SUB_W = 2,
   localparam int DUTY_W = TMR_W + SUB_W,
   localparam int RUN_BIT = SUB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [TMR_W-1:0]  wr_data,
   output logic [TMR_W-1:0]  period,
   output logic [DUTY_W-1:0] master_duty,
   output logic              run
);
   logic [TMR_W-1:0] duty_hi;
   logic [SUB_W-1:0] duty_lo;

   generate
      if (RUN_BIT >= TMR_W) begin : g_bad_ctrl
         $error("control byte too narrow for low duty bits and run bit");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period  <= '0;
         duty_hi <= '0;
         duty_lo <= '0;
         run     <= 1'b0;
      end else if (wr_en) begin
         case (reg_sel_t'(wr_sel))
            SEL_PERIOD:  period <= wr_data;
            SEL_DUTY_HI: duty_hi <= wr_data;
            SEL_CTRL: begin
               duty_lo <= wr_data[SUB_W-1:0];
               run     <= wr_data[RUN_BIT];
            end
            default: ;
         endcase
      end
   end

   assign master_duty = {duty_hi, duty_lo};

   // R4: duty-high write lands in the upper master bits
   a_r4_duty_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1) |=> master_duty[DUTY_W-1:SUB_W] == $past(wr_data));
endmodule

// File: rtl/pwm_dbuf_timebase.sv
module pwm_dbuf_timebase #(
   parameter int TMR_W = 8,
   parameter int SUB_W = 2,
   localparam int DUTY_W = TMR_W + SUB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic [TMR_W-1:0]  period,
   output logic [DUTY_W-1:0] tb,
   output logic [DUTY_W-1:0] tb_next,
   output logic              step,
   output logic              period_end
);
   logic [TMR_W-1:0] timer;
   logic [SUB_W-1:0] sub;
   logic             at_end;

   generate
      if (SUB_W < 1 || TMR_W < 2) begin : g_bad_width
         $error("timebase needs at least one sub bit and two timer bits");
      end
   endgenerate

   assign tb         = {timer, sub};
   assign tb_next    = tb + 1'b1;
   assign at_end     = (timer == period) && (sub == {SUB_W{1'b1}});
   assign period_end = run && tick && at_end;
   assign step       = run && tick && !at_end;

   always_ff @(posedge clk) begin
      if (!rst_n || !run || period_end) begin
         timer <= '0;
         sub   <= '0;
      end else if (step) begin
         {timer, sub} <= tb_next;
      end
   end

   // R1: no tick, no movement
   a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(tb));
   // R2: boundary returns the time base to zero
   a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |=> tb == '0);
   // R7: stopped time base sits at zero
   a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> tb == '0);
endmodule

// File: rtl/pwm_dbuf_compare.sv
module pwm_dbuf_compare #(
   parameter int DUTY_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              step,
   input  logic              period_end,
   input  logic [DUTY_W-1:0] tb_next,
   input  logic [DUTY_W-1:0] master_duty,
   output logic              pwm_out
);
   logic [DUTY_W-1:0] slave_duty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slave_duty <= '0;
         pwm_out    <= 1'b0;
      end else if (!run) begin
         pwm_out <= 1'b0;
      end else if (period_end) begin
         slave_duty <= master_duty;
         pwm_out    <= (master_duty != '0);
      end else if (step && tb_next == slave_duty) begin
         pwm_out <= 1'b0;
      end
   end

   // R5: slave copy changes only at a boundary
   a_r5_slave_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !period_end |=> $stable(slave_duty));
   // R3: output can only rise right after a boundary
   a_r3_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out) |-> $past(period_end));
   // R6: zero duty gives no pulse
   a_r6_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
      (period_end && master_duty == '0) |=> !pwm_out);
   // R7: stopped means low
   a_r7_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !pwm_out);
endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen #(
   parameter int TMR_W = 8,
   parameter int SUB_W = 2,
   localparam int DUTY_W = TMR_W + SUB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [TMR_W-1:0] wr_data,
   output logic             pwm_out
);
   logic [TMR_W-1:0]  period;
   logic [DUTY_W-1:0] master_duty;
   logic [DUTY_W-1:0] tb;
   logic [DUTY_W-1:0] tb_next;
   logic              run;
   logic              step;
   logic              period_end;

   pwm_dbuf_regs #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .period(period), .master_duty(master_duty), .run(run)
   );

   pwm_dbuf_timebase #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_en), .period(period),
      .tb(tb), .tb_next(tb_next), .step(step), .period_end(period_end)
   );

   pwm_dbuf_compare #(.DUTY_W(DUTY_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .run(run), .step(step), .period_end(period_end),
      .tb_next(tb_next), .master_duty(master_duty), .pwm_out(pwm_out)
   );

   // R8: first cycle after a stop-to-run change starts at zero, output low
   a_r8_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (tb == '0 && !pwm_out));
endmodule

// File: tb/test_pwm_dbuf_gen.sv
module test_pwm_dbuf_gen;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic       pwm_out;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   int tick_div = 1;
   int tick_cnt = 0;
   bit compare_on = 1'b0;
   string tag = "R7";

   // reference model state
   int m_per, m_dhi, m_ctrl, m_tb, m_slave;
   bit m_out;

   pwm_dbuf_gen i_pwm_dbuf_gen (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_per = 0; m_dhi = 0; m_ctrl = 0; m_tb = 0; m_slave = 0; m_out = 0;
      end else begin
         if (((m_ctrl >> 2) & 1) == 0) begin
            m_tb = 0;
            m_out = 0;
         end else if (tick_en) begin
            if (m_tb == m_per * 4 + 3) begin
               m_tb = 0;
               m_slave = m_dhi * 4 + (m_ctrl & 3);
               m_out = (m_slave != 0);
            end else begin
               m_tb = (m_tb + 1) % 1024;
               if (m_tb == m_slave) m_out = 0;
            end
         end
         if (wr_en) begin
            case (wr_sel)
               2'd0: m_per = wr_data;
               2'd1: m_dhi = wr_data;
               2'd2: m_ctrl = wr_data;
               default: ;
            endcase
         end
      end
   end

   task automatic check(string t, bit act, bit exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: pwm_out=%0b expected %0b at cycle %0d", t, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (compare_on) check(tag, pwm_out, m_out);
      tick_cnt++;
      tick_en <= (tick_cnt % tick_div) == 0;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: expired actual=%0d expected<=150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // measure cycles between two rising edges of the output
   task automatic period_len(output int len);
      bit prev;
      len = 0;
      prev = pwm_out;
      while (!( !prev && pwm_out)) begin prev = pwm_out; @(negedge clk); end
      prev = pwm_out;
      @(negedge clk); len = 1;
      while (!( !prev && pwm_out)) begin prev = pwm_out; @(negedge clk); len++; end
   endtask

   initial begin
      int len;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7", pwm_out, 1'b0); // reset state
      compare_on = 1'b1;

      // R8 and R3: period 3, duty 6 (hi 1, lo 2), tick every cycle
      tag = "R8";
      wr(2'd0, 8'd3);
      wr(2'd1, 8'd1);
      wr(2'd2, 8'h06);
      idle(14);
      tag = "R3";
      idle(60);

      // R4: low bits alone, duty hi 2 lo 1 = 9
      tag = "R4";
      wr(2'd1, 8'd2);
      wr(2'd2, 8'h05);
      idle(50);

      // R1: sparse ticks
      tag = "R1";
      tick_div = 3;
      idle(150);
      tick_div = 1;

      // R5: duty changed mid-period
      tag = "R5";
      idle(5);
      wr(2'd1, 8'd0);
      wr(2'd2, 8'h07);
      idle(50);

      // R6: zero duty, then oversized duty
      tag = "R6";
      wr(2'd1, 8'd0);
      wr(2'd2, 8'h04);
      idle(40);
      wr(2'd1, 8'd200);
      idle(50);

      // R2: period length with period 4 and a mid duty
      tag = "R2";
      wr(2'd0, 8'd4);
      wr(2'd1, 8'd2);
      idle(45);
      period_len(len);
      checks++;
      if (len != 20) begin
         fails++;
         $display("FAIL R2: period length=%0d expected 20", len);
      end
      wr(2'd0, 8'd0);
      wr(2'd1, 8'd0);
      wr(2'd2, 8'h06);
      idle(30);

      // R7: stop, then R8 restart
      tag = "R7";
      wr(2'd2, 8'h00);
      idle(1);
      check("R7", pwm_out, 1'b0);
      idle(20);
      tag = "R8";
      wr(2'd0, 8'd6);
      wr(2'd1, 8'd5);
      wr(2'd2, 8'h07);
      idle(120);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule